// File: doc/BRIEF.md
# ADC Test Pattern Generator

This block stands in the data path right after the converter. It either forwards the converter's 14-bit samples or swaps them for a known test word. Link bring-up and lane alignment use these words. A 3-bit mode field picks the source. Zero forwards live data. The other defined codes give a counting ramp, a constant zero word, a constant all-ones word, an alternating-bit word, or a half-ones/half-zeros framing word. One instance drives every channel, so all channels carry the same pattern when a test mode is active.

The output is one register that loads only when the sample strobe is high. A change of mode therefore shows up on the next accepted sample. The ramp counter also steps only on accepted samples. It starts over from zero each time ramp mode is entered afresh.

Top module: `tp_pattern_gen`

## Requirements
- R1: A synchronous active-high reset clears `tp_dout` to 0. While reset is high the data and mode inputs have no effect.
- R2: `tp_dout` loads one clock after a cycle with `smp_vld` high. In any cycle with `smp_vld` low it keeps its value.
- R3: Mode codes 3'b000, 3'b011 and 3'b101 forward `adc_din` unchanged.
- R4: Mode 3'b110 gives the word 0x0000.
- R5: Mode 3'b100 gives the word 0x3FFF (all bits one).
- R6: Mode 3'b010 gives the alternating word 0x1555 (14'b01010101010101, bit 0 set).
- R7: Mode 3'b001 gives the framing word 0x3F80 (14'b11111110000000, upper seven bits set).
- R8: The first accepted sample in mode 3'b111 gives 0, whether it follows reset or a sample in another mode.
- R9: Each later accepted sample in mode 3'b111 gives the previous ramp value plus one. Cycles with `smp_vld` low do not advance the ramp.
- R10: After the ramp reaches 0x3FFF, the next accepted ramp sample gives 0, and the count carries on from there.
- R11: An accepted sample in any mode other than 3'b111 breaks the ramp. The next ramp sample starts again from 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_vld | input | 1 | Strobe marking a cycle that carries a new sample |
| tp_mode | input | 3 | Test pattern select; 0 forwards live data |
| adc_din | input | 14 | Live converter sample |
| tp_dout | output | 14 | Registered sample or test word |

## Verification
Live data is forwarded under all three pass-through codes, using values that differ from every constant word, so a wrong mode decode cannot hide. Each constant mode runs with busy live data on the input, which shows the pattern really replaces it. The ramp is tried with gapped strobes to separate sample counting from clock counting. It is left and re-entered to expose a missing restart, and run through a full 16384-sample cycle to check the wrap back to zero. Holding `smp_vld` low between mode changes shows that the output and the counter both stay frozen.

// File: rtl/tp_pkg.sv
package tp_pkg;

  typedef enum logic [2:0] {
    TP_LIVE   = 3'b000,
    TP_FRAME  = 3'b001,
    TP_ALT    = 3'b010,
    TP_LIVE_A = 3'b011,
    TP_ONES   = 3'b100,
    TP_LIVE_B = 3'b101,
    TP_ZEROS  = 3'b110,
    TP_RAMP   = 3'b111
  } tp_mode_e;

  localparam int unsigned TP_MAX_W = 32;

  // alternating word, least significant bit set
  function automatic logic [TP_MAX_W-1:0] alt_word(input int unsigned w);
    logic [TP_MAX_W-1:0] r;
    r = '0;
    for (int unsigned i = 0; i < TP_MAX_W; i++)
      if (i < w) r[i] = (i % 2 == 0);
    return r;
  endfunction

  // upper half set, lower floor(w/2) bits clear
  function automatic logic [TP_MAX_W-1:0] frame_word(input int unsigned w);
    logic [TP_MAX_W-1:0] r;
    r = '0;
    for (int unsigned i = 0; i < TP_MAX_W; i++)
      if (i < w && i >= w / 2) r[i] = 1'b1;
    return r;
  endfunction

endpackage

// File: rtl/tp_ramp_ctr.sv
module tp_ramp_ctr #(
  parameter int unsigned W = 14
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         smp_vld,
  input  logic         ramp_sel,
  output logic [W-1:0] ramp_val
);
  logic [W-1:0] cnt_q;
  logic         in_ramp_q;
  logic         restart;

  assign restart  = ramp_sel && !in_ramp_q;
  assign ramp_val = restart ? '0 : cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      in_ramp_q <= 1'b0;
    end else if (smp_vld) begin
      in_ramp_q <= ramp_sel;
      if (ramp_sel) cnt_q <= ramp_val + 1'b1;
    end
  end
endmodule

// File: rtl/tp_word_sel.sv
module tp_word_sel #(
  parameter int unsigned W = 14
) (
  input  logic [2:0]   mode,
  input  logic [W-1:0] ramp_val,
  input  logic [W-1:0] live_din,
  output logic [W-1:0] word
);
  import tp_pkg::*;

  localparam logic [TP_MAX_W-1:0] ALT_FULL   = alt_word(W);
  localparam logic [TP_MAX_W-1:0] FRAME_FULL = frame_word(W);
  localparam logic [W-1:0]        ALT_W      = ALT_FULL[W-1:0];
  localparam logic [W-1:0]        FRAME_W    = FRAME_FULL[W-1:0];

  always_comb begin
    case (tp_mode_e'(mode))
      TP_RAMP:  word = ramp_val;
      TP_ZEROS: word = '0;
      TP_ONES:  word = '1;
      TP_ALT:   word = ALT_W;
      TP_FRAME: word = FRAME_W;
      default:  word = live_din;
    endcase
  end
endmodule

// File: rtl/tp_pattern_gen.sv
module tp_pattern_gen #(
  parameter int unsigned W = 14
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         smp_vld,
  input  logic [2:0]   tp_mode,
  input  logic [W-1:0] adc_din,
  output logic [W-1:0] tp_dout
);
  import tp_pkg::*;

  logic         ramp_sel;
  logic [W-1:0] ramp_val;
  logic [W-1:0] sel_word;

  assign ramp_sel = (tp_mode == TP_RAMP);

  tp_ramp_ctr #(.W(W)) ramp_i (
    .clk(clk), .rst(rst), .smp_vld(smp_vld),
    .ramp_sel(ramp_sel), .ramp_val(ramp_val)
  );

  tp_word_sel #(.W(W)) sel_i (
    .mode(tp_mode), .ramp_val(ramp_val),
    .live_din(adc_din), .word(sel_word)
  );

  always_ff @(posedge clk) begin
    if (rst)          tp_dout <= '0;
    else if (smp_vld) tp_dout <= sel_word;
  end
endmodule

// File: rtl/tp_pattern_gen_chk.sv
module tp_pattern_gen_chk #(
  parameter int unsigned W = 14
) (
  input logic         clk,
  input logic         rst,
  input logic         smp_vld,
  input logic [2:0]   tp_mode,
  input logic [W-1:0] adc_din,
  input logic [W-1:0] tp_dout
);
  logic last_ramp;
  always_ff @(posedge clk) begin
    if (rst)          last_ramp <= 1'b0;
    else if (smp_vld) last_ramp <= (tp_mode == 3'b111);
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> tp_dout == '0);
  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !smp_vld |=> $stable(tp_dout));
  // R3
  live_pass_chk: assert property (@(posedge clk) disable iff (rst)
    smp_vld && (tp_mode == 3'b000 || tp_mode == 3'b011 || tp_mode == 3'b101)
    |=> tp_dout == $past(adc_din));
  // R4
  zeros_word_chk: assert property (@(posedge clk) disable iff (rst)
    smp_vld && tp_mode == 3'b110 |=> tp_dout == '0);
  // R5
  ones_word_chk: assert property (@(posedge clk) disable iff (rst)
    smp_vld && tp_mode == 3'b100 |=> &tp_dout);
  // R6
  alt_word_chk: assert property (@(posedge clk) disable iff (rst)
    smp_vld && tp_mode == 3'b010 |=> tp_dout[0] && !tp_dout[1]);
  // R7
  frame_word_chk: assert property (@(posedge clk) disable iff (rst)
    smp_vld && tp_mode == 3'b001 |=> tp_dout[W-1] && !tp_dout[0]);
  // R8
  ramp_entry_chk: assert property (@(posedge clk) disable iff (rst)
    smp_vld && tp_mode == 3'b111 && !last_ramp |=> tp_dout == '0);
  // R9
  ramp_step_chk: assert property (@(posedge clk) disable iff (rst)
    smp_vld && tp_mode == 3'b111 && last_ramp |=> tp_dout == W'($past(tp_dout) + 1'b1));
endmodule

bind tp_pattern_gen tp_pattern_gen_chk #(.W(W)) chk_i (.*);

// File: tb/tp_pattern_gen_tb_top.sv
`timescale 1ns/1ps
module tp_pattern_gen_tb_top;
  localparam int W = 14;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         smp_vld = 1'b0;
  logic [2:0]   tp_mode = 3'b000;
  logic [W-1:0] adc_din = '0;
  logic [W-1:0] tp_dout;

  always #2 clk = ~clk;

  tp_pattern_gen #(.W(W)) dut_i (
    .clk(clk), .rst(rst), .smp_vld(smp_vld),
    .tp_mode(tp_mode), .adc_din(adc_din), .tp_dout(tp_dout)
  );

  typedef struct { logic [W-1:0] val; string req; } exp_t;
  exp_t exp_q[$];

  int checks = 0, errors = 0;
  bit done = 0;

  logic [W-1:0] m_out = '0, m_cnt = '0;
  bit m_in_ramp = 0;

  // driver: one cycle of stimulus, expected output pushed into scoreboard
  task automatic step(input bit r, input bit v, input logic [2:0] m,
                      input logic [W-1:0] d, input string req);
    exp_t e;
    @(negedge clk);
    rst = r; smp_vld = v; tp_mode = m; adc_din = d;
    if (r) begin
      m_out = '0; m_cnt = '0; m_in_ramp = 0;
    end else if (v) begin
      case (m)
        3'b111: begin
          if (!m_in_ramp) m_cnt = '0;
          m_out = m_cnt; m_cnt = m_cnt + 1'b1;
        end
        3'b110: m_out = 14'h0000;
        3'b100: m_out = 14'h3FFF;
        3'b010: m_out = 14'h1555;
        3'b001: m_out = 14'h3F80;
        default: m_out = d;
      endcase
      m_in_ramp = (m == 3'b111);
    end
    e.val = m_out; e.req = req;
    exp_q.push_back(e);
  endtask

  // monitor
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      checks++;
      if (tp_dout !== e.val) begin
        errors++;
        $display("FAIL %s: tp_dout=%h expected=%h", e.req, tp_dout, e.val);
      end
    end
  end

  initial begin
    #(4 * 190000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset dominates busy inputs
    for (int i = 0; i < 3; i++) step(1, 1, 3'b100, 14'h2A5A, "R1");
    // R3: pass-through codes
    step(0, 1, 3'b000, 14'h1234, "R3");
    step(0, 1, 3'b000, 14'h0ABC, "R3");
    step(0, 1, 3'b011, 14'h2222, "R3");
    step(0, 1, 3'b101, 14'h0F0F, "R3");
    // R2: no strobe, output holds while inputs change
    step(0, 0, 3'b110, 14'h3333, "R2");
    step(0, 0, 3'b100, 14'h1111, "R2");
    // R4..R7 constant words with busy live data
    step(0, 1, 3'b110, 14'h2BCD, "R4");
    step(0, 1, 3'b100, 14'h0001, "R5");
    step(0, 0, 3'b010, 14'h0002, "R2");
    step(0, 1, 3'b010, 14'h0003, "R6");
    step(0, 1, 3'b001, 14'h0004, "R7");
    // R8/R9: ramp with gaps
    step(0, 1, 3'b111, 14'h1000, "R8");
    for (int i = 0; i < 10; i++) begin
      step(0, 1, 3'b111, 14'h1000, "R9");
      step(0, 0, 3'b111, 14'h1000, "R9");
    end
    // R11: leave and re-enter ramp
    step(0, 1, 3'b000, 14'h0777, "R11");
    step(0, 1, 3'b111, 14'h0777, "R11");
    step(0, 1, 3'b111, 14'h0777, "R11");
    // R11: a gap in another mode without strobe keeps the ramp going
    step(0, 0, 3'b110, 14'h0777, "R11");
    step(0, 1, 3'b111, 14'h0777, "R11");
    // R10: full cycle through wrap
    for (int i = 0; i < 16390; i++) step(0, 1, 3'b111, 14'h0000, "R10");
    // R1: reset mid-ramp, then ramp restarts
    step(1, 1, 3'b111, 14'h0000, "R1");
    step(0, 1, 3'b111, 14'h0000, "R8");
    step(0, 1, 3'b111, 14'h0000, "R9");
    step(0, 0, 3'b000, 14'h0000, "R2");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule